// File: doc/BRIEF.md
# Bulk Erase Sequencer with Verify and Retry

This block drives the whole-array electrical erase of a byte-wide non-volatile memory. After a start request it raises the erase strobe and the high-voltage request and holds the program strobe low for a fixed number of clock cycles. It then reads the array back, one location per cycle, to confirm that every bit of every byte is one. When a byte comes back with any zero bit, the sweep stops at that byte and a new erase pulse follows at once. This repeats until a sweep completes cleanly or the attempt limit is used up.

The high-voltage source and the array itself sit outside the block. The block only issues requests on its pins and samples the data returned on the read port. At the end it reports done, a pass/fail result and the number of erase pulses it used. These stay valid until the next start.

Top module: `erase_verify_ctrl`

## Requirements
- R1: After reset: busy=0, done=0, pass=0, eraseStb=0, hvReq=0, pgmN=1, memCeN=1, memOeN=1, tryCount=0.
- R2: A start seen at a clock edge while idle or finished makes busy=1 and eraseStb=1 in the very next cycle, with done=0 and pass=0.
- R3: Each erase pulse holds eraseStb=1, hvReq=1 and pgmN=0 for exactly ERASE_CYCLES consecutive cycles. memCeN and memOeN stay 1 throughout the pulse.
- R4: Each erase pulse is followed directly by a verify sweep. The sweep reads addresses 0, 1, 2 and so on, one per cycle, with memCeN=0, memOeN=0, pgmN=1, hvReq=1 and eraseStb=0. memData is sampled at the clock edge that ends each read cycle.
- R5: A byte that is not all ones (8'hFF for the default width) ends the sweep in that same cycle. If the attempt limit has not been reached, the next cycle starts a new erase pulse.
- R6: done=1 with pass=1 is reported only after a sweep that reads all 2^ADDR_W locations as all ones.
- R7: If the sweep after attempt number MAX_TRIES (default 200) finds a bad byte, the block reports done=1 with pass=0 and issues no further pulse.
- R8: tryCount reports the number of erase pulses issued in the current run. Its final value equals the number of pulses observed on eraseStb.
- R9: A start input while busy is ignored. The run continues unchanged and its pulse count and result are unaffected.
- R10: While finished without a new start, done, pass and tryCount hold their values and all memory-side strobes stay inactive. A later start begins a fresh run whose count starts again at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an erase run |
| busy | output | 1 | Run in progress (erasing or verifying) |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Array verified all ones |
| tryCount | output | TRY_W | Erase pulses issued in the run |
| eraseStb | output | 1 | Erase pulse request |
| hvReq | output | 1 | High-voltage request to the external supply |
| pgmN | output | 1 | Program strobe, active low |
| memAddr | output | ADDR_W | Read address |
| memData | input | DATA_W | Read data from the array |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |

## Verification
The bench pairs the block with a model memory in which each byte becomes all ones after its own number of pulses. The test patterns are:
- A model that clears on the first pulse checks a single full sweep.
- Late bytes scattered through the array show whether the sweep really stops at the first bad address. Their effect is visible in the total read count across attempts.
- A byte that needs exactly the limit of pulses, compared with one that never clears, separates the last allowed pass from the fail report.
- A start pulsed mid-run shows that the block does not restart.

// File: rtl/erase_ctl_pkg.sv
package erase_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ERASE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_FINISH = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;    // new run: attempt count to 1, result cleared
    logic clrTimer;  // restart pulse timer
    logic tickTimer; // advance pulse timer
    logic clrAddr;   // sweep back to address 0
    logic incAddr;   // next location
    logic incTries;  // one more attempt
    logic setPass;   // clean sweep finished
  } dpCmd_t;

endpackage

// File: rtl/erase_dp.sv
module erase_dp
  import erase_ctl_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int MAX_TRIES    = 200,
  parameter int TRY_W        = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] memData,
  output logic              timerDone,
  output logic              addrLast,
  output logic              byteOk,
  output logic              triesMax,
  output logic [ADDR_W-1:0] addr,
  output logic [TRY_W-1:0]  tries,
  output logic              passFlag
);

  localparam int TMR_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] ADDR_END = {ADDR_W{1'b1}};
  localparam logic [TRY_W-1:0]  TRY_END  = TRY_W'(MAX_TRIES);

  logic [TMR_W-1:0] timer;
  logic [DATA_W-1:0] bitOk;

  // per-lane erased check
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lane
      assign bitOk[gi] = memData[gi];
    end
  endgenerate

  assign byteOk    = &bitOk;
  assign timerDone = (timer == TMR_END);
  assign addrLast  = (addr == ADDR_END);
  assign triesMax  = (tries == TRY_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (cmd.clrTimer) begin
      timer <= '0;
    end else if (cmd.tickTimer && !timerDone) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (cmd.clrAddr) begin
      addr <= '0;
    end else if (cmd.incAddr) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tries    <= '0;
      passFlag <= 1'b0;
    end else if (cmd.clrRun) begin
      tries    <= TRY_W'(1);
      passFlag <= 1'b0;
    end else begin
      if (cmd.incTries && !triesMax) tries <= tries + 1'b1;
      if (cmd.setPass) passFlag <= 1'b1;
    end
  end

  p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_END);
  p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_END);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.incAddr |=> addr == $past(addr) + 1'b1);
  p_run_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrRun |=> tries == TRY_W'(1) && !passFlag);

endmodule

// File: rtl/erase_fsm.sv
module erase_fsm
  import erase_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   timerDone,
  input  logic   addrLast,
  input  logic   byteOk,
  input  logic   triesMax,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done,
  output logic   eraseStb,
  output logic   hvReq,
  output logic   pgmN,
  output logic   memCeN,
  output logic   memOeN
);

  ctlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE, ST_FINISH: begin
        if (start) begin
          cmd.clrRun   = 1'b1;
          cmd.clrTimer = 1'b1;
          nextState    = ST_ERASE;
        end
      end
      ST_ERASE: begin
        cmd.tickTimer = 1'b1;
        if (timerDone) begin
          cmd.clrAddr = 1'b1;
          nextState   = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (!byteOk) begin
          if (triesMax) begin
            nextState = ST_FINISH;
          end else begin
            cmd.incTries = 1'b1;
            cmd.clrTimer = 1'b1;
            nextState    = ST_ERASE;
          end
        end else if (addrLast) begin
          cmd.setPass = 1'b1;
          nextState   = ST_FINISH;
        end else begin
          cmd.incAddr = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign eraseStb = (state == ST_ERASE);
  assign pgmN     = (state != ST_ERASE);
  assign hvReq    = (state == ST_ERASE) || (state == ST_VERIFY);
  assign memCeN   = (state != ST_VERIFY);
  assign memOeN   = (state != ST_VERIFY);
  assign busy     = hvReq;
  assign done     = (state == ST_FINISH);

  p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eraseStb) |-> $past(timerDone));
  p_fail_at_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERIFY && !byteOk) |=> (done == $past(triesMax)));
  p_pulse_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && !timerDone) |=> state == ST_ERASE);
  p_stop_on_bad_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERIFY && !byteOk && !triesMax) |=> eraseStb);

endmodule

// File: rtl/erase_verify_ctrl.sv
module erase_verify_ctrl
  import erase_ctl_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int MAX_TRIES    = 200,
  parameter int TRY_W        = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [TRY_W-1:0]  tryCount,
  output logic              eraseStb,
  output logic              hvReq,
  output logic              pgmN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memOeN
);

  dpCmd_t cmd;
  logic timerDone, addrLast, byteOk, triesMax;

  erase_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerDone (timerDone),
    .addrLast  (addrLast),
    .byteOk    (byteOk),
    .triesMax  (triesMax),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .eraseStb  (eraseStb),
    .hvReq     (hvReq),
    .pgmN      (pgmN),
    .memCeN    (memCeN),
    .memOeN    (memOeN)
  );

  erase_dp #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ERASE_CYCLES (ERASE_CYCLES),
    .MAX_TRIES    (MAX_TRIES),
    .TRY_W        (TRY_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .memData   (memData),
    .timerDone (timerDone),
    .addrLast  (addrLast),
    .byteOk    (byteOk),
    .triesMax  (triesMax),
    .addr      (memAddr),
    .tries     (tryCount),
    .passFlag  (pass)
  );

  p_pass_only_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

endmodule

// File: tb/sim_erase_verify_ctrl.sv
module sim_erase_verify_ctrl;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int ECYC   = 20;
  localparam int MAXT   = 200;
  localparam int TRY_W  = $clog2(MAXT + 1);
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass, eraseStb, hvReq, pgmN, memCeN, memOeN;
  logic [TRY_W-1:0] tryCount;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  int need [DEPTH];
  int memPulses = 0;
  int total = 0;
  int bad = 0;

  // model: byte clears once it has seen its own number of pulses
  assign memData = (memPulses >= need[memAddr]) ? {DATA_W{1'b1}} : 8'h7F;

  always #4 clk = ~clk;

  erase_verify_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ECYC),
                      .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .pass(pass), .tryCount(tryCount), .eraseStb(eraseStb), .hvReq(hvReq),
    .pgmN(pgmN), .memAddr(memAddr), .memData(memData), .memCeN(memCeN),
    .memOeN(memOeN));

  initial begin
    #1_500_000;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expReads(input int tries);
    int sum = 0;
    for (int k = 1; k <= tries; k++) begin
      int firstBad = -1;
      for (int a = 0; a < DEPTH; a++)
        if (firstBad < 0 && need[a] > k) firstBad = a;
      sum += (firstBad < 0) ? DEPTH : firstBad + 1;
    end
    return sum;
  endfunction

  function automatic int expTries();
    int mx = 1;
    for (int a = 0; a < DEPTH; a++) if (need[a] > mx) mx = need[a];
    return (mx > MAXT) ? MAXT : mx;
  endfunction

  task automatic fillNeed(input int base);
    for (int a = 0; a < DEPTH; a++) need[a] = base;
  endtask

  // one run: start, monitor every cycle at negedge, check at the end
  task automatic runOp(input string tag, input int injectAt);
    int pulses = 0, curLen = 0, badLen = 0, reads = 0, readIdx = 0;
    int badSeq = 0, badPins = 0, cyc = 0, eTries, ePass;
    memPulses = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R2 busy"}, int'(busy), 1);
    check({tag, " R2 eraseStb"}, int'(eraseStb), 1);
    check({tag, " R2 done/pass clear"}, int'(done) + int'(pass), 0);
    while (!done && cyc < 60000) begin
      if (cyc == injectAt) start = 1'b1;
      else start = 1'b0;
      if (eraseStb) begin
        if (pgmN || !hvReq || !memOeN || !memCeN) badPins++;
        if (curLen == 0) readIdx = 0;
        curLen++;
      end else begin
        if (curLen > 0) begin
          pulses++; memPulses++;
          if (curLen != ECYC) badLen++;
          curLen = 0;
        end
        if (!memOeN) begin
          if (memCeN || !pgmN || !hvReq) badPins++;
          if (int'(memAddr) != readIdx) badSeq++;
          readIdx++; reads++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    eTries = expTries();
    ePass = (expTries() >= need[0] && expReads(eTries) > 0) ? 1 : 0;
    for (int a = 0; a < DEPTH; a++) if (need[a] > MAXT) ePass = 0;
    check({tag, " finished"}, int'(done), 1);
    check({tag, " R3 pulse length errors"}, badLen, 0);
    check({tag, " R3/R4 pin state errors"}, badPins, 0);
    check({tag, " R4 address order errors"}, badSeq, 0);
    check({tag, " R5 total verify reads"}, reads, expReads(eTries));
    check({tag, " R6/R7 pass"}, int'(pass), ePass);
    check({tag, " R8 tryCount"}, int'(tryCount), eTries);
    check({tag, " R8 pulses seen"}, pulses, eTries);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 pass", int'(pass), 0);
    check("R1 strobes", int'(eraseStb) + int'(hvReq), 0);
    check("R1 pgmN/ceN/oeN", int'(pgmN) + int'(memCeN) + int'(memOeN), 3);
    check("R1 tryCount", int'(tryCount), 0);
  endtask

  task automatic t_clean();
    fillNeed(1);
    runOp("clean", -1);
  endtask

  task automatic t_retry();
    fillNeed(1);
    need[10] = 3; need[40] = 4; need[63] = 2;
    runOp("retry R5", -1);
  endtask

  task automatic t_ignore();
    fillNeed(1);
    need[20] = 2;
    runOp("ignore R9 erase", 5);
    runOp("ignore R9 verify", ECYC + 3);
  endtask

  task automatic t_limit_ok();
    fillNeed(1);
    need[0] = MAXT;
    runOp("limit pass R7", -1);
  endtask

  task automatic t_limit_fail();
    fillNeed(1);
    need[5] = MAXT + 1;
    runOp("limit fail R7", -1);
  endtask

  task automatic t_hold();
    int moved = 0;
    int tc = int'(tryCount);
    int ps = int'(pass);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!done || int'(pass) != ps || int'(tryCount) != tc) moved++;
      if (eraseStb || hvReq || !memOeN || !memCeN || !pgmN) moved++;
    end
    check("R10 hold while finished", moved, 0);
    fillNeed(1);
    runOp("R10 restart", -1);
  endtask

  initial begin
    fillNeed(1);
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_clean();
    t_retry();
    t_ignore();
    t_limit_ok();
    t_limit_fail();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule